// File: doc/BRIEF.md
# Grouped GPIO Event Detector with Sample Gating

This block watches 32 synchronized general-purpose input pins and records per-pin events in a sticky status vector. Each pin can be set to flag a low level, a high level, a rising transition, a falling transition, or any mix of these. An interrupt line is raised whenever a status bit is set and its per-pin interrupt enable is on. Software clears status bits by writing ones to a clear input.

Detection does not run on every clock. A shared divider thins sampling to one cycle in every N (N = 1, 2, 4 or 8). The pins are split into four banks of eight, and a bank's detection logic is enabled only when at least one of its pins has some detection type configured. Transitions are judged between two consecutive enabled samples, so timing precision follows the effective sampling rate. After a bank comes back from being gated off, its first enabled cycle only reloads the stored sample, so no false transition appears.

Top module: `gpio_evt_gate`

## Requirements
- R1: Pins form four banks of eight (bank b holds pins 8b to 8b+7). A bank none of whose pins has any detection type enabled sets no status bit, whatever its pins do.
- R2: `div_sel` selects N as 00 = 1, 01 = 2, 10 = 4, 11 = 8. Detection is enabled on the k-th clock after reset release (k = 0, 1, ...) exactly when k mod N is 0; status bits rise only after such cycles.
- R3: On an enabled cycle, a pin with low-level detection and a 0 input, or with high-level detection and a 1 input, sets its status bit, visible after that clock edge.
- R4: Rising (falling) detection compares the current sample against the sample taken on the bank's previous enabled cycle, not the previous clock; a pulse that starts and ends between enabled cycles is not seen.
- R5: Status bits are sticky: they stay set until a 1 is written to the matching bit of `clr_w1c`, which clears it after the next edge.
- R6: `irq` is high exactly when some status bit is set and its bit in `irq_en` is 1.
- R7: On the first enabled cycle after a bank turns from gated to active, the stored sample is reloaded and no transition event is reported for that bank.
- R8: When a clear and a new event for the same pin fall in the same cycle, the status bit ends set.
- R9: After synchronous reset, all status bits and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 32 | Synchronized pin values |
| cfg_low | input | 32 | Per-pin low-level detection enable |
| cfg_high | input | 32 | Per-pin high-level detection enable |
| cfg_rise | input | 32 | Per-pin rising-transition detection enable |
| cfg_fall | input | 32 | Per-pin falling-transition detection enable |
| div_sel | input | 2 | Sample thinning select (00=1, 01=2, 10=4, 11=8) |
| irq_en | input | 32 | Per-pin interrupt enable |
| clr_w1c | input | 32 | Write-one-to-clear strobe for status bits |
| status | output | 32 | Sticky per-pin event status |
| irq | output | 1 | Masked OR of status |

## Verification
The clear strobe and a fresh detection can land on the same pin in the same clock. The bench provokes this directly by holding a level condition true while strobing the clear bit, including under N = 2 where the clear alone wins on gated cycles and the event wins on enabled cycles, and it also lets random clears collide with random events. Each outcome is judged against a bench model that applies the clear before OR-ing in new events, so the bit must end set only where an enabled-cycle event was present.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    localparam int DIV_SEL_W = 2;
    localparam int DIV_CNT_W = 3;

    typedef enum logic [DIV_SEL_W-1:0] {
        DIV_BY_1 = 2'b00,
        DIV_BY_2 = 2'b01,
        DIV_BY_4 = 2'b10,
        DIV_BY_8 = 2'b11
    } div_sel_e;

    typedef struct packed {
        logic lvl_lo;
        logic lvl_hi;
        logic edge_up;
        logic edge_dn;
    } det_cfg_t;

    function automatic logic [DIV_CNT_W-1:0] div_mask(div_sel_e sel);
        logic [DIV_CNT_W-1:0] m;
        case (sel)
            DIV_BY_1: m = 3'd0;
            DIV_BY_2: m = 3'd1;
            DIV_BY_4: m = 3'd3;
            default:  m = 3'd7;
        endcase
        return m;
    endfunction

    function automatic logic pin_hit(det_cfg_t c, logic cur, logic prv, logic primed);
        logic lvl;
        logic edg;
        lvl = (c.lvl_lo & ~cur) | (c.lvl_hi & cur);
        edg = (c.edge_up & cur & ~prv) | (c.edge_dn & ~cur & prv);
        return lvl | (primed & edg);
    endfunction

endpackage

// File: rtl/gpio_evt_divider.sv
module gpio_evt_divider
    import gpio_evt_pkg::*;
#(
    parameter int CNT_W = DIV_CNT_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DIV_SEL_W-1:0] div_sel,
    output logic                 tick
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;

    assign mask = CNT_W'(div_mask(div_sel_e'(div_sel)));
    assign tick = (cnt_q & mask) == '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        (tick && div_sel != 2'b00) |=> (!tick || div_sel == 2'b00)); // R2

endmodule

// File: rtl/gpio_evt_group.sv
module gpio_evt_group
    import gpio_evt_pkg::*;
#(
    parameter int GW = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic     [GW-1:0]     pins,
    input  det_cfg_t [GW-1:0]     cfg,
    output logic                  active,
    output logic     [GW-1:0]     hits
);

    logic          en;
    logic [GW-1:0] prev_q;
    logic          primed_q;

    always_comb begin
        active = 1'b0;
        for (int i = 0; i < GW; i++) begin
            active = active | (|cfg[i]);
        end
    end

    assign en = tick & active;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else if (!active) begin
            primed_q <= 1'b0;
        end else if (en) begin
            primed_q <= 1'b1;
            prev_q   <= pins;
        end
    end

    for (genvar i = 0; i < GW; i++) begin : g_pin
        assign hits[i] = en & pin_hit(cfg[i], pins[i], prev_q[i], primed_q);
    end

    AST_REARM_AFTER_GATE: assert property (@(posedge clk) disable iff (rst)
        !active |=> !primed_q); // R7

endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] hits,
    input  logic [W-1:0] clr,
    input  logic [W-1:0] irq_en,
    output logic [W-1:0] status,
    output logic         irq
);

    logic [W-1:0] status_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr) | hits;
        end
    end

    assign status = status_q;
    assign irq    = |(status_q & irq_en);

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & $past(status_q & ~clr)) == $past(status_q & ~clr))); // R5

    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & $past(hits)) == $past(hits))); // R8

endmodule

// File: rtl/gpio_evt_gate.sv
module gpio_evt_gate
    import gpio_evt_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int GROUP_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PINS-1:0]  pin_in,
    input  logic [NUM_PINS-1:0]  cfg_low,
    input  logic [NUM_PINS-1:0]  cfg_high,
    input  logic [NUM_PINS-1:0]  cfg_rise,
    input  logic [NUM_PINS-1:0]  cfg_fall,
    input  logic [DIV_SEL_W-1:0] div_sel,
    input  logic [NUM_PINS-1:0]  irq_en,
    input  logic [NUM_PINS-1:0]  clr_w1c,
    output logic [NUM_PINS-1:0]  status,
    output logic                 irq
);

    localparam int NUM_GROUPS = NUM_PINS / GROUP_W;

    logic                          tick;
    det_cfg_t [NUM_PINS-1:0]       pin_cfg;
    logic     [NUM_PINS-1:0]       hits;
    logic     [NUM_GROUPS-1:0]     grp_act;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_cfg
        assign pin_cfg[p] = '{lvl_lo:  cfg_low[p],
                              lvl_hi:  cfg_high[p],
                              edge_up: cfg_rise[p],
                              edge_dn: cfg_fall[p]};
    end

    gpio_evt_divider #(.CNT_W(DIV_CNT_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .div_sel (div_sel),
        .tick    (tick)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
        gpio_evt_group #(.GW(GROUP_W)) u_grp (
            .clk    (clk),
            .rst    (rst),
            .tick   (tick),
            .pins   (pin_in[g*GROUP_W +: GROUP_W]),
            .cfg    (pin_cfg[g*GROUP_W +: GROUP_W]),
            .active (grp_act[g]),
            .hits   (hits[g*GROUP_W +: GROUP_W])
        );

        AST_IDLE_BANK_QUIET: assert property (@(posedge clk) disable iff (rst)
            !grp_act[g] |=> ((status[g*GROUP_W +: GROUP_W]
                              & ~$past(status[g*GROUP_W +: GROUP_W])) == '0)); // R1
    end

    gpio_evt_status #(.W(NUM_PINS)) u_stat (
        .clk    (clk),
        .rst    (rst),
        .hits   (hits),
        .clr    (clr_w1c),
        .irq_en (irq_en),
        .status (status),
        .irq    (irq)
    );

    AST_RISE_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ((status & ~$past(status)) == '0)); // R2

    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status != '0)); // R6

endmodule

// File: tb/gpio_evt_gate_test.sv
module gpio_evt_gate_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pin = '0, lo = '0, hi = '0, ru = '0, fa = '0;
    logic [31:0] ien = '0, clr = '0;
    logic [1:0]  sel = 2'b00;
    logic [31:0] status;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int k = 0;
    logic [31:0] mstat = '0;
    logic [31:0] mprev = '0;
    logic [3:0]  mprimed = '0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_evt_gate uut (
        .clk(clk), .rst(rst), .pin_in(pin),
        .cfg_low(lo), .cfg_high(hi), .cfg_rise(ru), .cfg_fall(fa),
        .div_sel(sel), .irq_en(ien), .clr_w1c(clr),
        .status(status), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock: model the requirements, advance, compare
    task automatic step(input string tag);
        int n;
        bit tk;
        logic [31:0] evt;
        logic [31:0] any;
        logic act;
        n = 1 << sel;
        tk = (k % n) == 0;
        any = lo | hi | ru | fa;
        evt = '0;
        for (int g = 0; g < 4; g++) begin
            act = |any[g*8 +: 8];
            for (int i = 0; i < 8; i++) begin
                int p;
                p = g*8 + i;
                if (tk && act)
                    evt[p] = (lo[p] & ~pin[p]) | (hi[p] & pin[p])
                           | (mprimed[g] & ru[p] & pin[p] & ~mprev[p])
                           | (mprimed[g] & fa[p] & ~pin[p] & mprev[p]);
            end
            if (!act) mprimed[g] = 1'b0;
            else if (tk) begin
                mprimed[g] = 1'b1;
                mprev[g*8 +: 8] = pin[g*8 +: 8];
            end
        end
        mstat = (mstat & ~clr) | evt;
        k++;
        @(posedge clk);
        #1;
        chk(tag, status, mstat);
        chk({tag, " irq R6"}, {31'd0, irq}, {31'd0, |(mstat & ien)});
    endtask

    task automatic quiet();
        pin = '0; lo = '0; hi = '0; ru = '0; fa = '0; ien = '0;
        clr = '1;
        step("cleanup R5");
        clr = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd7741);
        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset status", status, 32'h0);
        chk("R9 reset irq", {31'd0, irq}, 32'h0);
        rst = 1'b0;
        k = 0;

        // R3 high and low levels, N = 1
        hi[3] = 1'b1; pin[3] = 1'b1; lo[5] = 1'b1;
        step("R3 level");
        chk("R3 high level bit", {31'd0, status[3]}, 32'd1);
        chk("R3 low level bit", {31'd0, status[5]}, 32'd1);

        // R5 sticky then cleared
        hi[3] = 1'b0; pin[3] = 1'b0;
        step("R5 hold");
        chk("R5 sticky", {31'd0, status[3]}, 32'd1);
        clr[3] = 1'b1;
        step("R5 clear");
        clr[3] = 1'b0;
        chk("R5 cleared", {31'd0, status[3]}, 32'd0);

        // R8 clear collides with live low-level event on pin 5
        clr[5] = 1'b1;
        step("R8 collide");
        chk("R8 event wins", {31'd0, status[5]}, 32'd1);
        clr[5] = 1'b0;

        // R6 interrupt masking
        step("R6 masked");
        chk("R6 irq masked", {31'd0, irq}, 32'd0);
        ien[5] = 1'b1;
        step("R6 unmasked");
        chk("R6 irq raised", {31'd0, irq}, 32'd1);
        quiet();

        // R2 with N = 2: clear held, so bit follows enabled cycles
        sel = 2'b01; lo[20] = 1'b1;
        clr[20] = 1'b1;
        for (int c = 0; c < 8; c++) begin
            bit was_tick;
            was_tick = (k % 2) == 0;
            step("R2 thinning");
            chk("R2 set only on enabled cycle", {31'd0, status[20]}, {31'd0, was_tick});
        end
        quiet();

        // R4 pulse between enabled cycles, N = 4
        sel = 2'b10; ru[10] = 1'b1;
        repeat (6) step("R4 prime");
        while ((k % 4) != 1) step("R4 align");
        pin[10] = 1'b1;
        step("R4 pulse");
        pin[10] = 1'b0;
        repeat (6) step("R4 after");
        chk("R4 short pulse unseen", {31'd0, status[10]}, 32'd0);
        pin[10] = 1'b1;
        repeat (4) step("R4 real edge");
        chk("R4 real edge seen", {31'd0, status[10]}, 32'd1);
        quiet();

        // R7 re-enable with pin already high, N = 1
        sel = 2'b00; pin[28] = 1'b1;
        repeat (3) step("R7 gated");
        ru[28] = 1'b1;
        step("R7 rearm");
        chk("R7 no false edge", {31'd0, status[28]}, 32'd0);
        pin[28] = 1'b0;
        step("R7 low");
        pin[28] = 1'b1;
        step("R7 edge");
        chk("R7 edge after rearm", {31'd0, status[28]}, 32'd1);
        quiet();

        // R1 bank 1 unconfigured while bank 0 active
        hi[0] = 1'b1;
        for (int c = 0; c < 6; c++) begin
            pin[15:8] = 8'($urandom);
            step("R1 idle bank");
        end
        chk("R1 bank stays clear", {24'd0, status[15:8]}, 32'd0);
        quiet();

        // random mix, all requirements against the model
        for (int c = 0; c < 600; c++) begin
            pin = $urandom;
            lo  = $urandom & $urandom & $urandom & $urandom;
            hi  = $urandom & $urandom & $urandom & $urandom;
            ru  = $urandom & $urandom;
            fa  = $urandom & $urandom;
            for (int g = 0; g < 4; g++) begin
                if (($urandom % 3) == 0) begin
                    lo[g*8 +: 8] = '0; hi[g*8 +: 8] = '0;
                    ru[g*8 +: 8] = '0; fa[g*8 +: 8] = '0;
                end
            end
            ien = $urandom;
            clr = $urandom & $urandom;
            if ((c % 40) == 0) sel = 2'($urandom);
            step("RAND R3");
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule